// File: doc/BRIEF.md
# Packed BCD Arithmetic Unit

This unit performs one byte of two-digit packed decimal arithmetic per clock. It can add two BCD bytes, subtract a source byte from a destination byte, or negate the destination byte, which means forming zero minus the operand minus the extend bit. The incoming extend bit takes part in every operation, so a multi-byte decimal number can be processed one byte at a time, starting with the least significant byte. Each step feeds the extend output back into the extend input of the next step.

The zero flag is sticky. An operation can clear it but never set it. A caller therefore presets zero before the first byte of a chain and reads a meaningful "whole number is zero" result after the last byte. The negative and overflow flags follow fixed, deterministic rules even where their meaning is not architecturally defined. Negating an operand whose value plus extend is zero produces no write. Operand fetch, address predecrement and instruction decode are outside this block.

Results and flags are registered. An operation presented with `in_valid` appears on the outputs one clock later. The outputs then hold until the next accepted operation.

Top module: `bcd_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `result`, `wr_en` and all five flag outputs are cleared to 0.
- R2: An operation accepted with `in_valid` high appears on the outputs at the next clock edge, with `out_valid` high. With `in_valid` low, `out_valid` drops and `result`, `wr_en` and the flags hold their values.
- R3: With `op` = 2'b00 (add) and valid BCD operands, `result` is the BCD form of (src + dst + x_in) mod 100. `c_out` and `x_out` are both 1 exactly when that sum is 100 or more.
- R4: With `op` = 2'b00 (add), `n_out` and `v_out` both equal bit 7 of `result`.
- R5: With `op` = 2'b01 (subtract) and valid BCD operands, `result` is the BCD form of (dst - src - x_in) mod 100. `c_out`, `x_out` and `n_out` are all 1 exactly when that difference is negative, and `v_out` is 0.
- R6: For every operation, `z_out` equals `z_in` AND (`result` == 0). The zero flag is never set by an operation.
- R7: With `op[1]` = 1 (negate), let t = (dst + x_in) mod 256 and d = (0x9A - t) mod 256, and suppose t != 0. Then `result` is d, except that when the low nibble of d is 0xA, `result` is (upper nibble of d plus 1) mod 16 followed by a zero low nibble. In this case `c_out` = `x_out` = 1, `n_out` equals bit 7 of `result`, and `v_out` = (NOT bit 7 of d) AND bit 7 of `result`. For valid BCD input the result is the BCD form of (100 - dst - x_in) mod 100.
- R8: With `op[1]` = 1 and t = 0, `wr_en` = 0, `result` = 0x00, `c_out` = `x_out` = 0, `v_out` = 0 and `n_out` = 1.
- R9: Negate is selected by `op[1]` alone, so `op` 2'b10 and 2'b11 behave identically. The `src` input has no effect on a negate.
- R10: `wr_en` is 1 after every add, every subtract and every negate with t != 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accept an operation this cycle |
| op | input | 2 | 00 add, 01 subtract, 1x negate |
| src | input | 8 | Source BCD byte (unused for negate) |
| dst | input | 8 | Destination BCD byte |
| x_in | input | 1 | Incoming extend bit |
| z_in | input | 1 | Incoming zero flag |
| out_valid | output | 1 | Registered result is from the last cycle's operation |
| result | output | 8 | Packed BCD result byte |
| wr_en | output | 1 | Destination should be written with `result` |
| x_out | output | 1 | Extend flag out |
| n_out | output | 1 | Negative flag out |
| z_out | output | 1 | Zero flag out (sticky) |
| v_out | output | 1 | Overflow flag out |
| c_out | output | 1 | Carry/borrow flag out |

## Verification
The only state in the unit is the output register. A wrong decimal adjustment, a misplaced borrow or a stale flag therefore shows on the ports one clock after the operation that caused it and on no later cycle. Add and subtract are swept over every pair of valid BCD bytes, with both extend values and both incoming zero values. Negate is swept over all 256 destination bytes, with both opcode encodings and varying source bytes. Any corruption of the zero flag, the skipped-write case or the digit wrap is therefore observed at the output directly after the operation that exposes it.

// File: rtl/bcd_pkg.sv
// Shared types and constants for the packed BCD arithmetic unit.
// Assumes two 4-bit digits per byte; intermediate sums are kept in a
// 12-bit wrap-around space so that borrows appear as large unsigned values.
package bcd_pkg;

    localparam int DIG_W  = 4;
    localparam int BYTE_W = 2 * DIG_W;
    localparam int WIDE_W = 12;

    localparam logic [WIDE_W-1:0] DIGIT_MAX  = 12'h009;
    localparam logic [WIDE_W-1:0] DIGIT_ADJ  = 12'h006;
    localparam logic [WIDE_W-1:0] BYTE_MAX   = 12'h099;
    localparam logic [WIDE_W-1:0] TENS_WRAP  = 12'h0A0;
    localparam logic [BYTE_W-1:0] NEG_BIAS   = 8'h9A;
    localparam logic [DIG_W-1:0]  DIGIT_TEN  = 4'hA;

    typedef enum logic [1:0] {
        OP_ADD     = 2'b00,
        OP_SUB     = 2'b01,
        OP_NEG     = 2'b10,
        OP_NEG_ALT = 2'b11
    } bcd_op_e;

    typedef struct packed {
        logic                wr;
        logic [BYTE_W-1:0]   res;
        logic                x;
        logic                n;
        logic                z;
        logic                v;
        logic                c;
    } bcd_out_t;

    // Low digit of a byte, widened into the intermediate space.
    function automatic logic [WIDE_W-1:0] low_wide(input logic [BYTE_W-1:0] b);
        return WIDE_W'(b[DIG_W-1:0]);
    endfunction

    // High digit of a byte, kept at its tens weight in the intermediate space.
    function automatic logic [WIDE_W-1:0] high_wide(input logic [BYTE_W-1:0] b);
        return WIDE_W'({b[BYTE_W-1:DIG_W], {DIG_W{1'b0}}});
    endfunction

endpackage

// File: rtl/bcd_add_path.sv
// Decimal add of two packed BCD bytes plus extend.
// The units digit is adjusted by six when its sum exceeds nine; a total
// above 0x99 raises carry and is brought back by subtracting 0xA0.
// Non-BCD inputs give a deterministic but unchecked result.
module bcd_add_path
    import bcd_pkg::*;
(
    input  logic [BYTE_W-1:0] src_i,
    input  logic [BYTE_W-1:0] dst_i,
    input  logic              x_i,
    output logic [BYTE_W-1:0] sum_o,
    output logic              carry_o
);

    logic [WIDE_W-1:0] unit_raw;
    logic [WIDE_W-1:0] unit_fix;
    logic [WIDE_W-1:0] full_raw;
    logic [WIDE_W-1:0] full_fix;

    // Units digit sum, decimal adjust, tens digit sum and final wrap.
    always_comb begin
        unit_raw = low_wide(src_i) + low_wide(dst_i) + WIDE_W'(x_i);
        unit_fix = (unit_raw > DIGIT_MAX) ? unit_raw + DIGIT_ADJ : unit_raw;
        full_raw = unit_fix + high_wide(src_i) + high_wide(dst_i);
        carry_o  = (full_raw > BYTE_MAX);
        full_fix = carry_o ? full_raw - TENS_WRAP : full_raw;
        sum_o    = full_fix[BYTE_W-1:0];
    end

endmodule

// File: rtl/bcd_sub_path.sv
// Decimal subtract: destination minus source minus extend.
// A units difference outside 0..9 (unsigned) is corrected by six; a total
// outside 0..0x99 is a borrow and is corrected by adding 0xA0.
// Non-BCD inputs give a deterministic but unchecked result.
module bcd_sub_path
    import bcd_pkg::*;
(
    input  logic [BYTE_W-1:0] src_i,
    input  logic [BYTE_W-1:0] dst_i,
    input  logic              x_i,
    output logic [BYTE_W-1:0] diff_o,
    output logic              borrow_o
);

    logic [WIDE_W-1:0] unit_raw;
    logic [WIDE_W-1:0] unit_fix;
    logic [WIDE_W-1:0] full_raw;
    logic [WIDE_W-1:0] full_fix;

    // Units digit difference, decimal adjust, tens difference and wrap.
    always_comb begin
        unit_raw = low_wide(dst_i) - low_wide(src_i) - WIDE_W'(x_i);
        unit_fix = (unit_raw > DIGIT_MAX) ? unit_raw - DIGIT_ADJ : unit_raw;
        full_raw = unit_fix + high_wide(dst_i) - high_wide(src_i);
        borrow_o = (full_raw > BYTE_MAX);
        full_fix = borrow_o ? full_raw + TENS_WRAP : full_raw;
        diff_o   = full_fix[BYTE_W-1:0];
    end

endmodule

// File: rtl/bcd_neg_path.sv
// Decimal negate: zero minus (operand + extend), formed as 0x9A minus the
// biased operand. A zero outcome suppresses the write and clears carry.
// Otherwise a units digit of 0xA wraps to zero with a carry into the tens
// digit, and overflow marks a sign change caused by that wrap.
module bcd_neg_path
    import bcd_pkg::*;
(
    input  logic [BYTE_W-1:0] dst_i,
    input  logic              x_i,
    output logic [BYTE_W-1:0] res_o,
    output logic              carry_o,
    output logic              neg_o,
    output logic              ovf_o,
    output logic              write_o
);

    logic [BYTE_W-1:0] biased;
    logic [BYTE_W-1:0] diff;
    logic [BYTE_W-1:0] wrapped;
    logic              is_zero;

    // Bias the operand and form the raw nine's-style difference.
    always_comb begin
        biased  = dst_i + BYTE_W'(x_i);
        diff    = NEG_BIAS - biased;
        is_zero = (biased == '0);
    end

    // Wrap a units digit of ten into the tens digit.
    always_comb begin
        if (diff[DIG_W-1:0] == DIGIT_TEN)
            wrapped = {diff[BYTE_W-1:DIG_W] + DIG_W'(1), {DIG_W{1'b0}}};
        else
            wrapped = diff;
    end

    // Select outputs for the zero and nonzero outcomes.
    always_comb begin
        if (is_zero) begin
            res_o   = '0;
            carry_o = 1'b0;
            neg_o   = diff[BYTE_W-1];
            ovf_o   = 1'b0;
            write_o = 1'b0;
        end else begin
            res_o   = wrapped;
            carry_o = 1'b1;
            neg_o   = wrapped[BYTE_W-1];
            ovf_o   = ~diff[BYTE_W-1] & wrapped[BYTE_W-1];
            write_o = 1'b1;
        end
    end

endmodule

// File: rtl/bcd_unit.sv
// Packed BCD add/subtract/negate unit with a one-cycle registered output.
// All three arithmetic paths evaluate in parallel; the opcode picks one.
// Zero is sticky: the outgoing flag is the incoming one ANDed with a zero
// result. Outputs hold while no operation is accepted.
module bcd_unit
    import bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [BYTE_W-1:0] src,
    input  logic [BYTE_W-1:0] dst,
    input  logic              x_in,
    input  logic              z_in,
    output logic              out_valid,
    output logic [BYTE_W-1:0] result,
    output logic              wr_en,
    output logic              x_out,
    output logic              n_out,
    output logic              z_out,
    output logic              v_out,
    output logic              c_out
);

    logic [BYTE_W-1:0] add_sum, sub_diff, neg_res;
    logic              add_c, sub_b, neg_c, neg_n, neg_v, neg_we;
    bcd_out_t          nxt;
    bcd_out_t          cur;
    bcd_op_e           op_sel;

    bcd_add_path u_add (
        .src_i   (src),
        .dst_i   (dst),
        .x_i     (x_in),
        .sum_o   (add_sum),
        .carry_o (add_c)
    );

    bcd_sub_path u_sub (
        .src_i    (src),
        .dst_i    (dst),
        .x_i      (x_in),
        .diff_o   (sub_diff),
        .borrow_o (sub_b)
    );

    bcd_neg_path u_neg (
        .dst_i   (dst),
        .x_i     (x_in),
        .res_o   (neg_res),
        .carry_o (neg_c),
        .neg_o   (neg_n),
        .ovf_o   (neg_v),
        .write_o (neg_we)
    );

    assign op_sel = bcd_op_e'(op);

    // Pick the active path and build the flag set it defines.
    always_comb begin
        nxt = '0;
        unique case (op_sel)
            OP_ADD: begin
                nxt.res = add_sum;
                nxt.c   = add_c;
                nxt.x   = add_c;
                nxt.n   = add_sum[BYTE_W-1];
                nxt.v   = add_sum[BYTE_W-1];
                nxt.wr  = 1'b1;
            end
            OP_SUB: begin
                nxt.res = sub_diff;
                nxt.c   = sub_b;
                nxt.x   = sub_b;
                nxt.n   = sub_b;
                nxt.v   = 1'b0;
                nxt.wr  = 1'b1;
            end
            OP_NEG, OP_NEG_ALT: begin
                nxt.res = neg_res;
                nxt.c   = neg_c;
                nxt.x   = neg_c;
                nxt.n   = neg_n;
                nxt.v   = neg_v;
                nxt.wr  = neg_we;
            end
            default: nxt = '0;
        endcase
        nxt.z = z_in & (nxt.res == '0);
    end

    // Output register: cleared by reset, loaded on an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            cur       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                cur <= nxt;
        end
    end

    assign result = cur.res;
    assign wr_en  = cur.wr;
    assign x_out  = cur.x;
    assign n_out  = cur.n;
    assign z_out  = cur.z;
    assign v_out  = cur.v;
    assign c_out  = cur.c;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result) && $stable(wr_en)
                      && $stable({x_out, n_out, z_out, v_out, c_out})); // R2

    AST_Z_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !z_in |=> !z_out); // R6

    AST_ADD_NV_BIT7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == OP_ADD |=> n_out == result[BYTE_W-1] && v_out == result[BYTE_W-1]); // R4

    AST_SUB_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == OP_SUB |=> !v_out && n_out == c_out); // R5

    AST_NEG_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op[1] && BYTE_W'(dst + BYTE_W'(x_in)) == '0
        |=> !wr_en && result == '0 && !c_out && !x_out && n_out && !v_out); // R8

    AST_ADDSUB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !op[1] |=> wr_en); // R10

endmodule

// File: tb/tb_bcd_unit.sv
// Self-checking bench: exhaustive BCD sweeps for add and subtract, full
// byte sweep for negate, plus reset and idle-hold checks.
module tb_bcd_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] op = 2'b00;
    logic [7:0] src = 8'h00;
    logic [7:0] dst = 8'h00;
    logic       x_in = 1'b0;
    logic       z_in = 1'b0;
    logic       out_valid, wr_en, x_out, n_out, z_out, v_out, c_out;
    logic [7:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src(src), .dst(dst), .x_in(x_in), .z_in(z_in),
        .out_valid(out_valid), .result(result), .wr_en(wr_en),
        .x_out(x_out), .n_out(n_out), .z_out(z_out), .v_out(v_out), .c_out(c_out)
    );

    // Packed view of the outputs: {wr, result, x, n, z, v, c}
    function automatic logic [12:0] observed();
        return {wr_en, result, x_out, n_out, z_out, v_out, c_out};
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (wr,res,x,n,z,v,c)", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one operation, wait for its capture edge, sample after it.
    task automatic apply(input logic [1:0] o, input logic [7:0] s, input logic [7:0] d,
                         input logic x, input logic z);
        @(negedge clk);
        in_valid = 1'b1; op = o; src = s; dst = d; x_in = x; z_in = z;
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        logic [12:0] last;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", observed(), 13'h0);
        check_bit("R1 out_valid", out_valid, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 R4 R6 R10: add; R5 R6 R10: subtract; all BCD pairs
        for (int a = 0; a < 100; a++) begin
            for (int b = 0; b < 100; b++) begin
                for (int x = 0; x < 2; x++) begin
                    for (int z = 0; z < 2; z++) begin
                        int s;
                        int d;
                        logic [7:0] r;
                        logic cy;
                        s  = a + b + x;
                        cy = (s >= 100);
                        r  = to_bcd(s % 100);
                        apply(2'b00, to_bcd(a), to_bcd(b), 1'(x), 1'(z));
                        check("R3 R4 R6 R10 add", observed(),
                              {1'b1, r, cy, r[7], 1'(z) & (r == 8'h00), r[7], cy});
                        check_bit("R2 add valid", out_valid, 1'b1);
                        d  = b - a - x;
                        cy = (d < 0);
                        r  = to_bcd((d + 100) % 100);
                        apply(2'b01, to_bcd(a), to_bcd(b), 1'(x), 1'(z));
                        check("R5 R6 R10 sub", observed(),
                              {1'b1, r, cy, cy, 1'(z) & (r == 8'h00), 1'b0, cy});
                    end
                end
            end
        end

        // R7 R8 R9: negate over every byte, both encodings, varying src
        for (int dv = 0; dv < 256; dv++) begin
            for (int x = 0; x < 2; x++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] t;
                    logic [7:0] df;
                    logic [7:0] w;
                    logic [12:0] e;
                    logic zz;
                    zz = 1'(k & 1);
                    t  = 8'(dv + x);
                    df = 8'h9A - t;
                    if (t == 8'h00) begin
                        e = {1'b0, 8'h00, 1'b0, 1'b1, zz, 1'b0, 1'b0};
                    end else begin
                        w = (df[3:0] == 4'hA) ? {df[7:4] + 4'h1, 4'h0} : df;
                        e = {1'b1, w, 1'b1, w[7], zz & (w == 8'h00), ~df[7] & w[7], 1'b1};
                        if (dv % 16 < 10 && dv / 16 < 10 && w != to_bcd((200 - (dv / 16) * 10 - (dv % 16) - x) % 100)) begin
                            failures++;
                            $display("FAIL R7 decimal actual=%h expected=%h", w, to_bcd((200 - (dv / 16) * 10 - (dv % 16) - x) % 100));
                        end
                    end
                    apply({1'b1, 1'(k >> 1)}, 8'((dv * 37 + k * 91) & 8'hFF), 8'(dv), 1'(x), zz);
                    check("R7 R8 R9 R10 neg", observed(), e);
                end
            end
        end

        // R2: idle cycle holds outputs while inputs change
        apply(2'b00, 8'h45, 8'h67, 1'b1, 1'b1);
        last = observed();
        check("R3 R4 pre-hold add", last, {1'b1, 8'h13, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
        @(negedge clk);
        in_valid = 1'b0; op = 2'b10; dst = 8'h00; src = 8'h99; x_in = 1'b0; z_in = 1'b1;
        @(posedge clk);
        #1;
        check("R2 hold", observed(), last);
        check_bit("R2 idle valid", out_valid, 1'b0);

        // R1: reset in the middle of operation clears everything
        @(negedge clk);
        in_valid = 1'b1; rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid reset", observed(), 13'h0);
        check_bit("R1 mid reset valid", out_valid, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

endmodule